// File: doc/BRIEF.md
# Camera Line Capture Buffer

This block captures pixel words arriving from a camera deserialiser on the camera clock and stores them in a dual-port RAM, so that a host on a separate bus clock can read them out afterwards. The camera supplies a parallel data word together with frame-valid and line-valid qualifiers and horizontal and vertical sync levels. A capture is armed by the host. It begins on the next rising edge of frame valid and ends when frame valid falls or the buffer is full.

The host sees three word-wide registers on a small address bus. The command register holds enable, clear, data-enable, interrupt-enable and start bits. The data register pops one stored word per read. The status register packs the host read pointer, the camera write pointer and the capture flags, together with the live qualifier and sync levels. Single-bit flags cross between the clocks through two-flop synchronisers. The write pointer crosses as a Gray code.

Top module: `cap_linebuf`

## Requirements
- R1: The command register is at address 1 and reads back what was written: bit 0 enable, bit 1 clear, bit 2 data enable, bit 3 interrupt enable, bit 4 start. Higher bits read as 0 and all bits are 0 after reset.
- R2: The status register is at address 2 with this layout: bits 10:0 host read pointer, bit 11 done, bit 12 host data ready, bit 13 line valid, bit 14 frame valid, bit 15 interrupt flag, bits 27:16 write pointer, bit 28 zero, bit 29 camera data ready, bit 30 horizontal sync, bit 31 vertical sync. The whole word is 0 after reset when all camera inputs are low.
- R3: Once enable and start are set, no word is stored until the next rising edge of frame valid. From that edge on, qualified words are stored at consecutive RAM addresses starting at 0. Without start, a frame stores nothing.
- R4: Only words with frame valid, line valid and data enable all high are stored. A frame captured with data enable low ends with done set and a write pointer of 0.
- R5: Done sets when frame valid falls during a capture, or when the write pointer reaches DEPTH, even while frame valid is still high. Done stays set, and no further word is stored, until a clear.
- R6: Each read of address 0 returns the word at the host read pointer, one clock after the read strobe, and then advances the pointer by one. The stored words therefore come back in the order they were captured.
- R7: Status bit 12 is 1 while the host read pointer is below the synchronised write pointer. Status bit 29 is 1 once at least one word has been stored.
- R8: With interrupt enable set, done drives status bit 15 and the irq output high. With interrupt enable clear, both stay low.
- R9: While the clear bit is set, both pointers, done, both data-ready flags and the interrupt flag return to 0.
- R10: Status bits 13, 14, 30 and 31 follow the line valid, frame valid, horizontal sync and vertical sync inputs after synchronisation, whether or not a capture is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous active-high reset, host domain |
| host_addr | input | 2 | Register select: 0 data, 1 command, 2 status |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the clock after host_rd |
| irq | output | 1 | Interrupt request (done with interrupt enable) |
| cclk | input | 1 | Camera pixel clock |
| cam_rst | input | 1 | Synchronous active-high reset, camera domain |
| cam_pix | input | 32 | Camera data word |
| cam_fval | input | 1 | Frame valid qualifier |
| cam_lval | input | 1 | Line valid qualifier |
| cam_hsync | input | 1 | Horizontal sync level |
| cam_vsync | input | 1 | Vertical sync level |

## Verification
A register read answers at the host edge that follows the read strobe, so the bench raises the strobe on a falling edge and samples host_rdata on the next falling edge. Camera-side results reach the status word only after several stages: the command bits take two camera clocks to arrive, a stored word takes one camera clock to reach RAM, and the write pointer and flags take a Gray or flag register plus two host flops to cross back. The bench therefore waits ten camera clocks after any command before it drives a frame, and twenty host clocks after any camera activity before it reads status. The expected words, pointers and flags come from a bench model of the frames it drove.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int DATA_W = 32;
    localparam int HPTR_W = 11;
    localparam int CPTR_W = 12;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CMD  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // packed MSB first: start is bit 4, enable is bit 0
    typedef struct packed {
        logic start;
        logic irq_en;
        logic data_en;
        logic clear;
        logic enable;
    } cmd_t;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_ARM,
        WS_CAPT,
        WS_DONE
    } wr_state_e;

    typedef struct packed {
        logic              vsync;
        logic              hsync;
        logic              cam_rdy;
        logic              rsvd;
        logic [CPTR_W-1:0] wptr;
        logic              irq;
        logic              fval;
        logic              lval;
        logic              rdy;
        logic              done;
        logic [HPTR_W-1:0] hptr;
    } stat_t;

    function automatic logic [CPTR_W-1:0] bin2gray(input logic [CPTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CPTR_W-1:0] gray2bin(input logic [CPTR_W-1:0] g);
        logic [CPTR_W-1:0] b;
        b[CPTR_W-1] = g[CPTR_W-1];
        for (int i = CPTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cap_dpram.sv
module cap_dpram #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/cap_writer.sv
module cap_writer
    import cap_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int DW     = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              cclk,
    input  logic              cam_rst,
    input  cmd_t              cmd_c,
    input  logic [DW-1:0]     pix,
    input  logic              fval,
    input  logic              lval,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [DW-1:0]     ram_wdata,
    output logic [CPTR_W-1:0] wptr,
    output logic [CPTR_W-1:0] wptr_gray,
    output logic              has_data,
    output logic              done
);
    localparam logic [CPTR_W-1:0] LAST = CPTR_W'(DEPTH - 1);

    wr_state_e st;
    logic      fv_q;
    logic      rise;
    logic      open_win;
    logic      take;

    assign rise = fval & ~fv_q;

    always_comb begin
        open_win = (st == WS_CAPT && fval) ||
                   (st == WS_ARM && cmd_c.enable && rise);
        take     = open_win && lval && cmd_c.data_en;
    end

    // previous frame-valid level survives a clear so no false edge appears
    always_ff @(posedge cclk) begin
        if (cam_rst) fv_q <= 1'b0;
        else         fv_q <= fval;
    end

    always_ff @(posedge cclk) begin
        if (cam_rst || cmd_c.clear) begin
            st        <= WS_IDLE;
            wptr      <= '0;
            wptr_gray <= '0;
            done      <= 1'b0;
            has_data  <= 1'b0;
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we    <= take;
            wptr_gray <= bin2gray(wptr);
            if (take) begin
                ram_waddr <= wptr[AW-1:0];
                ram_wdata <= pix;
                wptr      <= wptr + 1'b1;
                has_data  <= 1'b1;
            end
            unique case (st)
                WS_IDLE: if (cmd_c.enable && cmd_c.start) st <= WS_ARM;
                WS_ARM: begin
                    if (!cmd_c.enable) st <= WS_IDLE;
                    else if (rise)     st <= WS_CAPT;
                end
                WS_CAPT: begin
                    if (!fval || (take && wptr == LAST)) begin
                        st   <= WS_DONE;
                        done <= 1'b1;
                    end
                end
                WS_DONE: st <= WS_DONE;
            endcase
        end
    end
endmodule

// File: rtl/cap_linebuf.sv
module cap_linebuf
    import cap_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              hclk,
    input  logic              rst,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq,
    input  logic              cclk,
    input  logic              cam_rst,
    input  logic [DATA_W-1:0] cam_pix,
    input  logic              cam_fval,
    input  logic              cam_lval,
    input  logic              cam_hsync,
    input  logic              cam_vsync
);
    localparam int NFLAG = 6;

    // host-domain state
    cmd_t              cmd_q;
    logic [CPTR_W-1:0] hptr;
    logic              irq_flag;
    reg_sel_e          sel;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] ram_q;
    logic              rd_data;
    stat_t             stat;
    logic              unused_wdata;

    // camera-domain state
    logic [4:0]        cmd_cam_v;
    cmd_t              cmd_cam;
    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic [CPTR_W-1:0] cam_wptr;
    logic [CPTR_W-1:0] cam_wgray;
    logic              cam_rdy;
    logic              cam_done;

    // crossed into host domain
    logic [NFLAG-1:0]  flags_h;
    logic [CPTR_W-1:0] wgray_h;
    logic [CPTR_W-1:0] wptr_h;
    logic              done_h;

    assign sel          = reg_sel_e'(host_addr);
    assign rd_data      = host_rd && sel == REG_DATA;
    assign unused_wdata = ^host_wdata[DATA_W-1:5];

    cap_sync #(.W(5)) u_cmd_sync (
        .clk(cclk), .rst(cam_rst), .d(cmd_q), .q(cmd_cam_v)
    );
    assign cmd_cam = cmd_t'(cmd_cam_v);

    cap_writer #(.DEPTH(DEPTH), .DW(DATA_W)) u_writer (
        .cclk     (cclk),
        .cam_rst  (cam_rst),
        .cmd_c    (cmd_cam),
        .pix      (cam_pix),
        .fval     (cam_fval),
        .lval     (cam_lval),
        .ram_we   (ram_we),
        .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata),
        .wptr     (cam_wptr),
        .wptr_gray(cam_wgray),
        .has_data (cam_rdy),
        .done     (cam_done)
    );

    cap_dpram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
        .wclk (cclk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .rclk (hclk),
        .re   (rd_data),
        .raddr(hptr[AW-1:0]),
        .rdata(ram_q)
    );

    cap_sync #(.W(NFLAG)) u_flag_sync (
        .clk(hclk), .rst(rst),
        .d  ({cam_done, cam_rdy, cam_fval, cam_lval, cam_hsync, cam_vsync}),
        .q  (flags_h)
    );

    cap_sync #(.W(CPTR_W)) u_ptr_sync (
        .clk(hclk), .rst(rst), .d(cam_wgray), .q(wgray_h)
    );

    assign wptr_h = gray2bin(wgray_h);
    assign done_h = flags_h[5];

    always_comb begin
        stat         = '0;
        stat.hptr    = hptr[HPTR_W-1:0];
        stat.done    = done_h;
        stat.rdy     = hptr < wptr_h;
        stat.lval    = flags_h[2];
        stat.fval    = flags_h[3];
        stat.irq     = irq_flag;
        stat.wptr    = wptr_h;
        stat.cam_rdy = flags_h[4];
        stat.hsync   = flags_h[1];
        stat.vsync   = flags_h[0];
    end

    always_ff @(posedge hclk) begin
        if (rst) begin
            cmd_q    <= '0;
            hptr     <= '0;
            irq_flag <= 1'b0;
            rd_sel   <= REG_NONE;
            reg_q    <= '0;
        end else begin
            if (host_wr && sel == REG_CMD) begin
                cmd_q <= cmd_t'(host_wdata[4:0]);
            end
            if (cmd_q.clear) begin
                hptr     <= '0;
                irq_flag <= 1'b0;
            end else begin
                if (rd_data) hptr <= hptr + 1'b1;
                irq_flag <= done_h & cmd_q.irq_en;
            end
            if (host_rd) begin
                rd_sel <= sel;
                unique case (sel)
                    REG_CMD:  reg_q <= {{(DATA_W-5){1'b0}}, cmd_q};
                    REG_STAT: reg_q <= stat;
                    default:  reg_q <= '0;
                endcase
            end
        end
    end

    assign host_rdata = (rd_sel == REG_DATA) ? ram_q : reg_q;
    assign irq        = irq_flag;
endmodule

// File: rtl/cap_linebuf_chk.sv
module cap_linebuf_chk
    import cap_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input logic              hclk,
    input logic              rst,
    input logic              cclk,
    input logic              cam_rst,
    input logic              host_rd,
    input logic [1:0]        host_addr,
    input cmd_t              cmd_q,
    input cmd_t              cmd_cam,
    input logic [CPTR_W-1:0] hptr,
    input logic              irq_flag,
    input logic              done_h,
    input logic [CPTR_W-1:0] cam_wptr,
    input logic              cam_done,
    input logic              ram_we,
    input logic              cam_fval,
    input logic              cam_lval
);
    // R5: pointer never passes the buffer end
    assert_wptr_bound_R5: assert property (@(posedge cclk) disable iff (cam_rst)
        cam_wptr <= CPTR_W'(DEPTH));

    // R5: done holds until a clear
    assert_done_sticky_R5: assert property (@(posedge cclk) disable iff (cam_rst)
        cam_done && !cmd_cam.clear |=> cam_done);

    // R5: no RAM write once done was set
    assert_no_write_after_done_R5: assert property (@(posedge cclk) disable iff (cam_rst)
        $past(cam_done) |-> !ram_we);

    // R4: a RAM write follows a cycle with both qualifiers high
    assert_we_qualified_R4: assert property (@(posedge cclk) disable iff (cam_rst)
        ram_we |-> $past(cam_fval && cam_lval));

    // R6: a data read advances the host pointer by one
    assert_hptr_step_R6: assert property (@(posedge hclk) disable iff (rst)
        host_rd && host_addr == 2'd0 && !cmd_q.clear |=> hptr == $past(hptr) + 1'b1);

    // R9: clear empties the host pointer and interrupt flag
    assert_clear_R9: assert property (@(posedge hclk) disable iff (rst)
        cmd_q.clear |=> hptr == '0 && !irq_flag);

    // R8: interrupt flag only from done with interrupt enable
    assert_irq_source_R8: assert property (@(posedge hclk) disable iff (rst)
        irq_flag |-> $past(done_h && cmd_q.irq_en));
endmodule

bind cap_linebuf cap_linebuf_chk #(.DEPTH(DEPTH)) u_chk (
    .hclk     (hclk),
    .rst      (rst),
    .cclk     (cclk),
    .cam_rst  (cam_rst),
    .host_rd  (host_rd),
    .host_addr(host_addr),
    .cmd_q    (cmd_q),
    .cmd_cam  (cmd_cam),
    .hptr     (hptr),
    .irq_flag (irq_flag),
    .done_h   (done_h),
    .cam_wptr (cam_wptr),
    .cam_done (cam_done),
    .ram_we   (ram_we),
    .cam_fval (cam_fval),
    .cam_lval (cam_lval)
);

// File: tb/cap_linebuf_bench.sv
module cap_linebuf_bench;
    localparam int DEPTH = 2048;

    logic        hclk = 1'b0;
    logic        cclk = 1'b0;
    logic        rst = 1'b1;
    logic        cam_rst = 1'b1;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;
    logic [31:0] cam_pix = '0;
    logic        cam_fval = 1'b0;
    logic        cam_lval = 1'b0;
    logic        cam_hsync = 1'b0;
    logic        cam_vsync = 1'b0;

    int checks = 0;
    int errs = 0;
    int hp = 0;
    logic [31:0] exp_q[$];

    always #2.5 hclk = ~hclk;
    always #4   cclk = ~cclk;

    cap_linebuf #(.DEPTH(DEPTH)) u_cap_linebuf (
        .hclk(hclk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .cclk(cclk), .cam_rst(cam_rst), .cam_pix(cam_pix),
        .cam_fval(cam_fval), .cam_lval(cam_lval), .cam_hsync(cam_hsync),
        .cam_vsync(cam_vsync)
    );

    function automatic logic [31:0] mk_stat(input int hptr, input bit done, input bit rdy,
                                            input bit lv, input bit fv, input bit irqf,
                                            input int wptr, input bit crdy,
                                            input bit hs, input bit vs);
        logic [31:0] h = 32'(hptr);
        logic [31:0] w = 32'(wptr);
        return {vs, hs, crdy, 1'b0, w[11:0], irqf, fv, lv, rdy, done, h[10:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic wait_h(input int n);
        repeat (n) @(posedge hclk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge hclk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge hclk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge hclk);
        host_addr = a; host_rd = 1'b1;
        @(negedge hclk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_cmd(input logic [31:0] c);
        host_write(2'd1, c);
        repeat (10) @(posedge cclk);
    endtask

    task automatic do_clear();
        host_write(2'd1, 32'h2);
        wait_h(20);
        hp = 0;
        exp_q.delete();
    endtask

    task automatic cam_frame(input int nlines, input bit keep);
        int len;
        @(negedge cclk);
        cam_fval = 1'b1; cam_lval = 1'b0; cam_pix = $urandom;
        repeat (2) @(negedge cclk);
        for (int l = 0; l < nlines; l++) begin
            len = 1 + int'($urandom % 8);
            for (int w = 0; w < len; w++) begin
                @(negedge cclk);
                cam_lval = 1'b1; cam_pix = $urandom;
                if (keep && exp_q.size() < DEPTH) exp_q.push_back(cam_pix);
            end
            for (int g = 0; g < 2; g++) begin
                @(negedge cclk);
                cam_lval = 1'b0; cam_pix = $urandom;
            end
        end
        @(negedge cclk);
        cam_fval = 1'b0;
        repeat (3) @(negedge cclk);
        wait_h(20);
    endtask

    task automatic read_all(input string req);
        logic [31:0] d;
        for (int i = 0; i < exp_q.size(); i++) begin
            host_read(2'd0, d);
            chk(req, d, exp_q[i]);
            hp++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge hclk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'h5eed_1234));
        repeat (6) @(posedge cclk);
        @(negedge hclk); rst = 1'b0;
        @(negedge cclk); cam_rst = 1'b0;
        wait_h(4);

        // reset state
        host_read(2'd2, d); chk("R2 status after reset", d, 32'h0);
        host_read(2'd1, d); chk("R1 command after reset", d, 32'h0);
        chk("R8 irq after reset", {31'b0, irq}, 32'h0);

        // random frames, armed and stored
        for (int it = 0; it < 3; it++) begin
            do_clear();
            set_cmd(32'h15);
            host_read(2'd1, d); chk("R1 command readback", d, 32'h15);
            cam_frame(1 + int'($urandom % 4), 1'b1);
            n = exp_q.size();
            host_read(2'd2, d);
            chk("R3 R5 R7 status after frame", d, mk_stat(0, 1, 1, 0, 0, 0, n, 1, 0, 0));
            read_all("R6 data order");
            host_read(2'd2, d);
            chk("R6 R7 status after reads", d, mk_stat(n, 1, 0, 0, 0, 0, n, 1, 0, 0));
        end

        // done is sticky: a further frame stores nothing
        n = exp_q.size();
        cam_frame(2, 1'b0);
        host_read(2'd2, d);
        chk("R5 sticky done", d, mk_stat(n, 1, 0, 0, 0, 0, n, 1, 0, 0));

        // clear empties everything
        do_clear();
        host_read(2'd2, d); chk("R9 clear status", d, 32'h0);

        // no start: frame ignored
        set_cmd(32'h05);
        cam_frame(2, 1'b0);
        host_read(2'd2, d); chk("R3 no start", d, 32'h0);

        // interrupt enabled
        set_cmd(32'h1D);
        cam_frame(2, 1'b1);
        n = exp_q.size();
        host_read(2'd2, d);
        chk("R8 irq status", d, mk_stat(0, 1, 1, 0, 0, 1, n, 1, 0, 0));
        chk("R8 irq pin", {31'b0, irq}, 32'h1);
        read_all("R6 data with irq");
        do_clear();
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);

        // data enable low
        set_cmd(32'h11);
        cam_frame(3, 1'b0);
        host_read(2'd2, d);
        chk("R4 data enable low", d, mk_stat(0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R8 irq stays low", {31'b0, irq}, 32'h0);

        // live levels
        do_clear();
        host_write(2'd1, 32'h0);
        @(negedge cclk);
        cam_fval = 1'b1; cam_lval = 1'b1; cam_hsync = 1'b1; cam_vsync = 1'b1;
        wait_h(20);
        host_read(2'd2, d);
        chk("R10 live levels", d, mk_stat(0, 0, 0, 1, 1, 0, 0, 0, 1, 1));
        @(negedge cclk);
        cam_fval = 1'b0; cam_lval = 1'b0; cam_hsync = 1'b0; cam_vsync = 1'b0;
        wait_h(20);
        host_read(2'd2, d); chk("R10 levels low", d, 32'h0);

        // buffer full before frame valid falls
        set_cmd(32'h15);
        @(negedge cclk);
        cam_fval = 1'b1; cam_lval = 1'b0;
        for (int w = 0; w < DEPTH + 5; w++) begin
            @(negedge cclk);
            cam_lval = 1'b1; cam_pix = $urandom;
            if (exp_q.size() < DEPTH) exp_q.push_back(cam_pix);
        end
        wait_h(20);
        host_read(2'd2, d);
        chk("R5 full with frame valid high", d, mk_stat(0, 1, 1, 1, 1, 0, DEPTH, 1, 0, 0));
        @(negedge cclk);
        cam_fval = 1'b0; cam_lval = 1'b0;
        wait_h(20);
        read_all("R6 full buffer data");
        host_read(2'd2, d);
        chk("R7 full buffer drained", d, mk_stat(DEPTH, 1, 0, 0, 0, 0, DEPTH, 1, 0, 0));

        summary();
    end
endmodule